// File: doc/BRIEF.md
# Stepwise Clock Divider Ramp

This block walks a 4-bit clock divider field down, one step at a time, from the value loaded with a control word to a target value. The clock frequency therefore rises in small increments and never jumps. After each step the block waits a fixed settle time, measured in microsecond ticks, and only then compares the divider with the target again. Once the divider is no longer above the target, the block raises `done` and holds the final word.

The target comes from one of two places. If the build-time constant `CFG_TARGET` lies in the range 1 to 10, the target is that constant. Otherwise the target is read from the low nibble of the control word.

The block takes in a control word and a start pulse. It presents the updated control word on its output, so the clock logic downstream can take the divider from that word.

Top module: `clkdiv_ramp`

## Requirements
- R1: The divider is the field at bits 11:8 of the control word. A `start` that is accepted loads `word_in`, and `word_out` shows that value after the next rising edge.
- R2: The target is `CFG_TARGET` when 1 <= `CFG_TARGET` <= 10. For any other value, the target is bits 3:0 of the loaded word.
- R3: Each step lowers the divider field by exactly one. All other bits of the word stay unchanged.
- R4: A step is taken one edge after a compare. The next compare follows only after `SETTLE_US` cycles in which `tick_us` was high. While the block settles, `word_out` does not change.
- R5: The ramp stops when the divider is no longer above the target. `done` then goes high. If the loaded divider was above the target, the final divider equals the target.
- R6: If the loaded divider does not exceed the target, `done` rises two edges after `start` and no step is taken.
- R7: After reset, `word_out` is 0 and `done` is 0.
- R8: A `start` while `done` is high begins a new ramp from a new word.
- R9: A `start` during a ramp is ignored. The ramp continues on the word it already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load `word_in` and begin a ramp |
| word_in | input | WORD_W | Initial control word |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| word_out | output | WORD_W | Current control word |
| done | output | 1 | High once the ramp is complete |

## Verification
The bench builds two instances side by side. Both use short settle windows, 4 ticks and 3 ticks, so that a 15-step ramp fits in a few hundred cycles. One instance takes `CFG_TARGET = 1`, inside the valid range. The other takes `CFG_TARGET = 12`, so its target falls back to the word's low nibble. Fed the same stimulus, the two instances reach both target sources, the already-met case, a target of zero, and a start that arrives mid-ramp.

// File: rtl/clkdiv_ramp.sv
module clkdiv_ramp #(
  parameter int WORD_W     = 32,
  parameter int DIV_LSB    = 8,
  parameter int DIV_W      = 4,
  parameter int CFG_TARGET = 1,
  parameter int SETTLE_US  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              tick_us,
  output logic [WORD_W-1:0] word_out,
  output logic              done
);
  localparam int CNT_W = $clog2(SETTLE_US + 1);
  localparam bit USE_CFG = (CFG_TARGET >= 1) && (CFG_TARGET <= 10);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SETTLE, S_DONE} st_t;

  st_t               state;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  div_cur, tgt;
  logic              accept, busy;

  assign div_cur  = word_q[DIV_LSB +: DIV_W];
  assign tgt      = USE_CFG ? DIV_W'(CFG_TARGET) : word_q[DIV_W-1:0];
  assign accept   = start && (state == S_IDLE || state == S_DONE);
  assign busy     = (state == S_CHECK) || (state == S_SETTLE);
  assign word_out = word_q;
  assign done     = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      word_q <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (accept) begin
          word_q <= word_in;
          state  <= S_CHECK;
        end
        S_CHECK: if (tgt < div_cur) begin
          word_q[DIV_LSB +: DIV_W] <= div_cur - DIV_W'(1);
          cnt   <= '0;
          state <= S_SETTLE;
        end else begin
          state <= S_DONE;
        end
        S_SETTLE: if (tick_us) begin
          if (cnt == CNT_W'(SETTLE_US - 1)) begin
            cnt   <= '0;
            state <= S_CHECK;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(word_q)) |->
      (div_cur == $past(div_cur) - DIV_W'(1)) &&
      ((word_q ^ $past(word_q)) & ~(WORD_W'((1 << DIV_W) - 1) << DIV_LSB)) == '0);

  assert_settle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE) |=> $stable(word_q));

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(SETTLE_US));

  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_cur <= tgt) || $past(div_cur <= tgt));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(start)) |-> !$rose(done) || $past(state == S_CHECK));
endmodule

// File: tb/test_clkdiv_ramp.sv
module test_clkdiv_ramp;
  logic clk = 0, rst_n = 0, start = 0, tick_us = 0;
  logic [31:0] word_in = '0;
  logic [31:0] wo_a, wo_b;
  logic done_a, done_b;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  clkdiv_ramp #(.CFG_TARGET(1), .SETTLE_US(4)) i_clkdiv_ramp (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
    .tick_us(tick_us), .word_out(wo_a), .done(done_a));

  clkdiv_ramp #(.CFG_TARGET(12), .SETTLE_US(3)) i_clkdiv_ramp_nib (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
    .tick_us(tick_us), .word_out(wo_b), .done(done_b));

  // behavioural reference: phase 0 idle, 1 compare, 2 settle, 3 finished
  logic [31:0] m_word [2];
  int m_ph [2], m_cnt [2];
  int settle [2] = '{4, 3};
  int cfg [2] = '{1, 12};

  function automatic int target_of(int i, logic [31:0] w);
    if (cfg[i] >= 1 && cfg[i] <= 10) return cfg[i];
    return int'(w[3:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_word[i] = 0; m_ph[i] = 0; m_cnt[i] = 0;
      end else begin
        case (m_ph[i])
          0, 3: if (start) begin m_word[i] = word_in; m_ph[i] = 1; end
          1: if (target_of(i, m_word[i]) < int'(m_word[i][11:8])) begin
               m_word[i] = m_word[i] - 32'h100; m_ph[i] = 2; m_cnt[i] = 0;
             end else m_ph[i] = 3;
          default: if (tick_us) begin
               m_cnt[i]++;
               if (m_cnt[i] == settle[i]) m_ph[i] = 1;
             end
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    chk(wo_a == m_word[0], "R1 R3 R4 word A", wo_a, m_word[0]);
    chk(wo_b == m_word[1], "R1 R2 R3 R4 word B", wo_b, m_word[1]);
    chk(done_a == (m_ph[0] == 3), "R5 R6 done A", 32'(done_a), 32'(m_ph[0] == 3));
    chk(done_b == (m_ph[1] == 3), "R5 R6 done B", 32'(done_b), 32'(m_ph[1] == 3));
    tick_us = (cyc % 2 == 0);
    start = 0;
  endtask

  function automatic logic [31:0] final_word(int i, logic [31:0] w);
    int t = target_of(i, w);
    if (int'(w[11:8]) > t) return {w[31:12], 4'(t), w[7:0]};
    return w;
  endfunction

  task automatic run(logic [31:0] w, string tag);
    int n = 0;
    word_in = w; start = 1;
    cycle();
    while (!(done_a && done_b) && n < 2000) begin cycle(); n++; end
    chk(wo_a == final_word(0, w), {tag, " R5 R3 final A"}, wo_a, final_word(0, w));
    chk(wo_b == final_word(1, w), {tag, " R2 R5 final B"}, wo_b, final_word(1, w));
    cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wo_a == 0 && wo_b == 0, "R7 reset word", wo_a | wo_b, 0);
    chk(!done_a && !done_b, "R7 reset done", 32'(done_a | done_b), 0);
    rst_n = 1;
    cycle();
    run(32'h1234_0703, "R1");
    // R6: B already meets target (2 <= 9); A steps once
    word_in = 32'hABCD_E2F9; start = 1;
    cycle();
    cycle();
    chk(done_b && wo_b == 32'hABCD_E2F9, "R6 no-step done B", wo_b, 32'hABCD_E2F9);
    repeat (20) cycle();
    chk(wo_a == 32'hABCD_E1F9, "R8 restart from done A", wo_a, 32'hABCD_E1F9);
    // R9: start in mid-ramp is ignored
    word_in = 32'h5500_0F00; start = 1;
    repeat (6) cycle();
    word_in = 32'h0000_0300; start = 1;
    cycle();
    chk(wo_a[31:24] == 8'h55, "R9 ignored start A", wo_a, m_word[0]);
    begin
      int n = 0;
      while (!(done_a && done_b) && n < 2000) begin cycle(); n++; end
    end
    chk(wo_a == 32'h5500_0100, "R9 R5 final A", wo_a, 32'h5500_0100);
    chk(wo_b == 32'h5500_0000, "R2 R5 zero target B", wo_b, 32'h5500_0000);
    cycle();
    run(32'h0000_0000, "R6");
    run(32'hFFFF_FAF4, "R2");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule